// File: doc/BRIEF.md
# Security Attribution Lookup Unit

This block labels every bus address with one of three security classes: Secure, Non-Secure-Callable or Non-Secure. Two sources feed the label. A fixed vendor map, hard-wired at build time, treats one address bit as an alias selector. Up to eight programmable windows refine the result. When the two sources disagree, the stricter class is used. So the programmable windows can relax space that the vendor map leaves open, but they can never weaken vendor-Secure space.

Software programs the windows through a small register port. Each window has a base and a limit, both on a 32-byte grain, plus an enable bit and a callable bit. Only accesses that are both privileged and secure may touch these registers. Any other access reads back zero, changes nothing and raises a one-cycle violation pulse.

The lookup port is combinational. It returns the final class and a flag that says whether a programmable window decided the result. The same port also checks a branch that leaves Non-Secure code, and it raises a fault when the target is not a legal gateway entry.

Top module: `sec_attr_unit`

## Requirements
- R1: After reset the global enable is clear, every lookup reports Secure (encoding 2) with `lkHit` low, `cfgViolation` is low, and a read of register 0 returns 0.
- R2: Take an address with the vendor bit (bit 28) clear, inside exactly one enabled window, with the callable bit clear. It reports Non-Secure (encoding 0) with `lkHit` high. The window covers base <= address <= (limit | 0x1F), and both ends are included.
- R3: The same single enabled-window hit with the callable bit set reports Non-Secure-Callable (encoding 1).
- R4: An address outside every enabled window reports Secure with `lkHit` low. A disabled window matches nothing.
- R5: An address inside two or more enabled windows reports Secure with `lkHit` high.
- R6: An address with bit 28 set is vendor-Secure and always reports Secure, whatever the windows say. Encoding 2 is stricter than 1, and 1 is stricter than 0.
- R7: Register 0, bit 0, is the global enable. While it is clear, every address reports Secure with `lkHit` low, and the window settings are kept.
- R8: The register map works as follows. Register 0 is control. Register 1+2i is the base of window i, using bits [31:5]. Register 2+2i is the limit of window i: bits [31:5] hold the limit, bit 1 is the callable bit and bit 0 is the enable. A privileged secure read returns the stored word on `cfgRdata` one cycle later; the unused bits read as zero. `cfgRdata` is zero in any cycle that follows no allowed read.
- R9: An access whose `cfgPriv` and `cfgSecure` are not both high is handled as follows. A write changes no register. A read returns zero. In both cases `cfgViolation` is high for exactly the cycle after the access.
- R10: While `brCheck` is high, `secFault` follows the class of the target. It is high if the target class is Secure. It is high if the class is Non-Secure-Callable and `brOp` is not 0xE97F. It is low if the class is Non-Secure, or if the class is Non-Secure-Callable and `brOp` equals 0xE97F. With `brCheck` low, `secFault` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgValid | input | 1 | Register access request this cycle |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgPriv | input | 1 | Requester is privileged |
| cfgSecure | input | 1 | Requester is in the Secure state |
| cfgAddr | input | 5 | Register index |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data, one cycle after an allowed read |
| cfgViolation | output | 1 | One-cycle pulse after a refused access |
| lkAddr | input | 32 | Address to classify, also the branch target |
| lkAttr | output | 2 | Final class: 0 Non-Secure, 1 Callable, 2 Secure |
| lkHit | output | 1 | A programmable window decided the result |
| brCheck | input | 1 | A branch from Non-Secure code targets `lkAddr` |
| brOp | input | 16 | First halfword at the branch target |
| secFault | output | 1 | Illegal entry flagged |

## Verification
The bench probes both ends of each window: the base itself, the last byte of the limit granule, and one byte on either side. A design that forgot the `| 0x1F` rule, or that used a strict compare, would misclassify exactly those bytes. Overlapping windows must come out Secure. A design that took the first match would instead leak the Non-Secure class, and a vendor-Secure address inside an open window catches a combine step that is wrong or missing. Refused register accesses come from non-privileged and non-secure requesters, and a later lookup must show the old window unchanged. Branch checks cover all four class-and-opcode pairings, and random window programming compares against a bench model.

// File: rtl/sec_attr_pkg.sv
package sec_attr_pkg;

  typedef enum logic [1:0] {
    ATTR_NS  = 2'd0,
    ATTR_NSC = 2'd1,
    ATTR_S   = 2'd2
  } attr_e;

  localparam int REG_IDX_W = 3;

  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic                 selCtl;
    logic                 selBase;
    logic                 selLim;
    logic [REG_IDX_W-1:0] region;
  } cfg_strobe_t;

  function automatic attr_e stricterOf(attr_e a, attr_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sec_attr_ctrl.sv
module sec_attr_ctrl
  import sec_attr_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int CFG_AW      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic              cfgPriv,
  input  logic              cfgSecure,
  input  logic [CFG_AW-1:0] cfgAddr,
  output cfg_strobe_t       strb,
  output logic              cfgViolation
);

  localparam int LAST_IDX = 2 * NUM_REGIONS;

  logic              accOk;
  logic [CFG_AW-1:0] offset;

  assign accOk  = cfgValid && cfgPriv && cfgSecure;
  assign offset = cfgAddr - CFG_AW'(1);

  always_comb begin
    strb      = '0;
    strb.wrEn = accOk && cfgWrite;
    strb.rdEn = accOk && !cfgWrite;
    if (cfgAddr == '0) begin
      strb.selCtl = 1'b1;
    end else if (int'(cfgAddr) <= LAST_IDX) begin
      strb.selBase = ~offset[0];
      strb.selLim  = offset[0];
      strb.region  = REG_IDX_W'(offset >> 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgViolation <= 1'b0;
    else       cfgViolation <= cfgValid && !(cfgPriv && cfgSecure);
  end

endmodule

// File: rtl/sec_attr_dp.sv
module sec_attr_dp
  import sec_attr_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          NUM_REGIONS = 8,
  parameter int          VENDOR_BIT  = 28,
  parameter logic [15:0] GATE_OP     = 16'hE97F
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strb,
  input  logic [ADDR_W-1:0] cfgWdata,
  output logic [ADDR_W-1:0] cfgRdata,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic [1:0]        lkAttr,
  output logic              lkHit,
  input  logic              brCheck,
  input  logic [15:0]       brOp,
  output logic              secFault
);

  localparam int NR_EFF = (NUM_REGIONS > 0) ? NUM_REGIONS : 1;
  localparam int HI_W   = ADDR_W - 5;

  logic            globalEn;
  logic [HI_W-1:0] baseQ [NR_EFF];
  logic [HI_W-1:0] limQ  [NR_EFF];
  logic [NR_EFF-1:0] enQ, nscQ, hitVec;
  logic [HI_W-1:0] addrHi;
  logic [ADDR_W-1:0] rdNext;
  attr_e progAttr, vendorAttr, finalAttr;
  int hitCount;

  assign addrHi = lkAddr[ADDR_W-1:5];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           globalEn <= 1'b0;
    else if (strb.wrEn && strb.selCtl)   globalEn <= cfgWdata[0];
  end

  generate
    if (NUM_REGIONS > 0) begin : g_regions
      for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            baseQ[r] <= '0;
            limQ[r]  <= '0;
            enQ[r]   <= 1'b0;
            nscQ[r]  <= 1'b0;
          end else if (strb.wrEn && int'(strb.region) == r) begin
            if (strb.selBase) baseQ[r] <= cfgWdata[ADDR_W-1:5];
            if (strb.selLim) begin
              limQ[r] <= cfgWdata[ADDR_W-1:5];
              nscQ[r] <= cfgWdata[1];
              enQ[r]  <= cfgWdata[0];
            end
          end
        end
        assign hitVec[r] = enQ[r] && (addrHi >= baseQ[r]) && (addrHi <= limQ[r]);
      end
    end else begin : g_none
      assign baseQ[0] = '0;
      assign limQ[0]  = '0;
      assign enQ      = '0;
      assign nscQ     = '0;
      assign hitVec   = '0;
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    if (strb.selCtl) rdNext[0] = globalEn;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (int'(strb.region) == r) begin
        if (strb.selBase) rdNext = {baseQ[r], 5'b0};
        if (strb.selLim)  rdNext = {limQ[r], 3'b0, nscQ[r], enQ[r]};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgRdata <= '0;
    else       cfgRdata <= strb.rdEn ? rdNext : '0;
  end

  always_comb begin
    hitCount = $countones(hitVec);
    if (!globalEn || hitCount != 1) progAttr = ATTR_S;
    else if ((hitVec & nscQ) != '0) progAttr = ATTR_NSC;
    else                            progAttr = ATTR_NS;
  end

  assign vendorAttr = lkAddr[VENDOR_BIT] ? ATTR_S : ATTR_NS;
  assign finalAttr  = stricterOf(vendorAttr, progAttr);
  assign lkAttr     = finalAttr;
  assign lkHit      = globalEn && (hitVec != '0);
  assign secFault   = brCheck && ((finalAttr == ATTR_S) ||
                                  (finalAttr == ATTR_NSC && brOp != GATE_OP));

endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit
  import sec_attr_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          NUM_REGIONS = 8,
  parameter int          CFG_AW      = 5,
  parameter int          VENDOR_BIT  = 28,
  parameter logic [15:0] GATE_OP     = 16'hE97F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic              cfgPriv,
  input  logic              cfgSecure,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgWdata,
  output logic [ADDR_W-1:0] cfgRdata,
  output logic              cfgViolation,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic [1:0]        lkAttr,
  output logic              lkHit,
  input  logic              brCheck,
  input  logic [15:0]       brOp,
  output logic              secFault
);

  cfg_strobe_t strb;

  sec_attr_ctrl #(.NUM_REGIONS(NUM_REGIONS), .CFG_AW(CFG_AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgPriv(cfgPriv), .cfgSecure(cfgSecure), .cfgAddr(cfgAddr),
    .strb(strb), .cfgViolation(cfgViolation)
  );

  sec_attr_dp #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS),
                .VENDOR_BIT(VENDOR_BIT), .GATE_OP(GATE_OP)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .lkAddr(lkAddr), .lkAttr(lkAttr), .lkHit(lkHit),
    .brCheck(brCheck), .brOp(brOp), .secFault(secFault)
  );

endmodule

// File: rtl/sec_attr_chk.sv
module sec_attr_chk #(
  parameter int          ADDR_W     = 32,
  parameter int          VENDOR_BIT = 28,
  parameter logic [15:0] GATE_OP    = 16'hE97F
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgValid,
  input logic              cfgPriv,
  input logic              cfgSecure,
  input logic [ADDR_W-1:0] cfgRdata,
  input logic              cfgViolation,
  input logic [ADDR_W-1:0] lkAddr,
  input logic [1:0]        lkAttr,
  input logic              lkHit,
  input logic              brCheck,
  input logic [15:0]       brOp,
  input logic              secFault
);

  // R9: a refused access yields a zero read and a violation pulse next cycle
  p_refused_access_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !(cfgPriv && cfgSecure)) |=> (cfgViolation && cfgRdata == '0));

  // R9: the pulse only follows a refused access
  p_violation_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgViolation |-> $past(cfgValid && !(cfgPriv && cfgSecure)));

  // R6: vendor-Secure space never reports a weaker class
  p_vendor_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    lkAddr[VENDOR_BIT] |-> (lkAttr == 2'd2));

  // R4: a weaker-than-Secure class needs a window hit
  p_relax_needs_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lkAttr != 2'd2) |-> lkHit);

  // R10: a fault only appears for a checked branch
  p_fault_needs_branch_r10: assert property (@(posedge clk) disable iff (!rstN)
    secFault |-> brCheck);

  // R10: a gateway opcode in a callable window is a legal entry
  p_gateway_ok_r10: assert property (@(posedge clk) disable iff (!rstN)
    (brCheck && lkAttr == 2'd1 && brOp == GATE_OP) |-> !secFault);

  // R10: a branch landing in Secure space always faults
  p_secure_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    (brCheck && lkAttr == 2'd2) |-> secFault);

endmodule

bind sec_attr_unit sec_attr_chk #(
  .ADDR_W(ADDR_W), .VENDOR_BIT(VENDOR_BIT), .GATE_OP(GATE_OP)
) chk_i (
  .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgPriv(cfgPriv),
  .cfgSecure(cfgSecure), .cfgRdata(cfgRdata), .cfgViolation(cfgViolation),
  .lkAddr(lkAddr), .lkAttr(lkAttr), .lkHit(lkHit), .brCheck(brCheck),
  .brOp(brOp), .secFault(secFault)
);

// File: tb/sec_attr_unit_tb_top.sv
`timescale 1ns/1ps
module sec_attr_unit_tb_top;

  localparam logic [15:0] GATE = 16'hE97F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 1'b0, cfgWrite = 1'b0, cfgPriv = 1'b0, cfgSecure = 1'b0;
  logic [4:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        cfgViolation;
  logic [31:0] lkAddr = '0;
  logic [1:0]  lkAttr;
  logic        lkHit;
  logic        brCheck = 1'b0;
  logic [15:0] brOp = '0;
  logic        secFault;

  int passCnt = 0;
  int totalCnt = 0;

  logic [26:0] mBase [8];
  logic [26:0] mLim  [8];
  logic [7:0]  mEn, mNsc;
  logic        mGlob;

  always #4 clk = ~clk;

  sec_attr_unit dut_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgPriv(cfgPriv), .cfgSecure(cfgSecure), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .cfgViolation(cfgViolation),
    .lkAddr(lkAddr), .lkAttr(lkAttr), .lkHit(lkHit), .brCheck(brCheck),
    .brOp(brOp), .secFault(secFault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s: actual %h expected %h", req, act, exp);
  endtask

  function automatic int countHits(input logic [31:0] a);
    int n = 0;
    for (int r = 0; r < 8; r++)
      if (mEn[r] && a[31:5] >= mBase[r] && a[31:5] <= mLim[r]) n++;
    return n;
  endfunction

  function automatic logic [1:0] expAttr(input logic [31:0] a);
    int n;
    logic nsc;
    if (a[28] || !mGlob) return 2'd2;
    n = countHits(a);
    if (n != 1) return 2'd2;
    nsc = 1'b0;
    for (int r = 0; r < 8; r++)
      if (mEn[r] && a[31:5] >= mBase[r] && a[31:5] <= mLim[r]) nsc = mNsc[r];
    return nsc ? 2'd1 : 2'd0;
  endfunction

  function automatic logic expHit(input logic [31:0] a);
    return mGlob && countHits(a) != 0;
  endfunction

  function automatic logic expFault(input logic [1:0] at, input logic [15:0] op);
    return (at == 2'd2) || (at == 2'd1 && op != GATE);
  endfunction

  // One register access; returns the registered read data and violation flag
  task automatic cfgAccess(input logic wr, input logic pr, input logic sc,
                           input logic [4:0] ad, input logic [31:0] wd,
                           output logic [31:0] rd, output logic viol);
    @(negedge clk);
    cfgValid = 1'b1; cfgWrite = wr; cfgPriv = pr; cfgSecure = sc;
    cfgAddr = ad; cfgWdata = wd;
    @(negedge clk);
    rd = cfgRdata; viol = cfgViolation;
    cfgValid = 1'b0;
    if (wr && pr && sc) begin
      if (ad == 0) mGlob = wd[0];
      else if (ad <= 16) begin
        if (ad[0]) mBase[(ad-1)>>1] = wd[31:5];
        else begin
          mLim[(ad-1)>>1] = wd[31:5];
          mNsc[(ad-1)>>1] = wd[1];
          mEn[(ad-1)>>1]  = wd[0];
        end
      end
    end
  endtask

  task automatic psWrite(input logic [4:0] ad, input logic [31:0] wd);
    logic [31:0] rd;
    logic v;
    cfgAccess(1'b1, 1'b1, 1'b1, ad, wd, rd, v);
  endtask

  task automatic look(input string req, input logic [31:0] a,
                      input logic [1:0] expA, input logic expH);
    @(negedge clk);
    lkAddr = a; brCheck = 1'b0;
    #1;
    check(req, {30'b0, lkAttr}, {30'b0, expA});
    check(req, {31'b0, lkHit}, {31'b0, expH});
  endtask

  task automatic branch(input string req, input logic [31:0] a,
                        input logic [15:0] op, input logic expF);
    @(negedge clk);
    lkAddr = a; brCheck = 1'b1; brOp = op;
    #1;
    check(req, {31'b0, secFault}, {31'b0, expF});
    brCheck = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    totalCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic v;
    logic [31:0] a;
    logic [31:0] seedDummy;
    for (int r = 0; r < 8; r++) begin mBase[r] = '0; mLim[r] = '0; end
    mEn = '0; mNsc = '0; mGlob = 1'b0;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    look("R1", 32'h0000_0100, 2'd2, 1'b0);
    check("R1", {31'b0, cfgViolation}, 32'd0);
    cfgAccess(1'b0, 1'b1, 1'b1, 5'd0, 32'd0, rd, v);
    check("R1", rd, 32'd0);

    // Program windows
    psWrite(5'd0, 32'h1);
    psWrite(5'd1, 32'h0000_1000); psWrite(5'd2, 32'h0000_10E1); // win0 NS
    psWrite(5'd3, 32'h0000_2000); psWrite(5'd4, 32'h0000_2003); // win1 NSC
    look("R2", 32'h0000_1000, 2'd0, 1'b1);
    look("R2", 32'h0000_10FF, 2'd0, 1'b1);
    look("R4", 32'h0000_0FFF, 2'd2, 1'b0);
    look("R4", 32'h0000_1100, 2'd2, 1'b0);
    look("R3", 32'h0000_2010, 2'd1, 1'b1);

    // R5: overlap
    psWrite(5'd5, 32'h0000_1080); psWrite(5'd6, 32'h0000_1081);
    look("R5", 32'h0000_1090, 2'd2, 1'b1);
    look("R5", 32'h0000_1000, 2'd0, 1'b1);

    // R6: vendor-Secure alias
    psWrite(5'd7, 32'h1000_1000); psWrite(5'd8, 32'h1000_1001);
    look("R6", 32'h1000_1010, 2'd2, 1'b1);

    // R4: disabled window
    psWrite(5'd9, 32'h0000_3000); psWrite(5'd10, 32'h0000_3000);
    look("R4", 32'h0000_3000, 2'd2, 1'b0);

    // R8: readback
    cfgAccess(1'b0, 1'b1, 1'b1, 5'd4, 32'd0, rd, v);
    check("R8", rd, 32'h0000_2003);
    cfgAccess(1'b0, 1'b1, 1'b1, 5'd3, 32'd0, rd, v);
    check("R8", rd, 32'h0000_2000);
    check("R8", {31'b0, v}, 32'd0);
    @(negedge clk);
    check("R8", cfgRdata, 32'd0);

    // R9: refused accesses
    cfgAccess(1'b1, 1'b1, 1'b0, 5'd1, 32'h0000_5000, rd, v);
    check("R9", {31'b0, v}, 32'd1);
    @(negedge clk);
    check("R9", {31'b0, cfgViolation}, 32'd0);
    cfgAccess(1'b1, 1'b0, 1'b1, 5'd2, 32'h0000_0000, rd, v);
    check("R9", {31'b0, v}, 32'd1);
    look("R9", 32'h0000_1000, 2'd0, 1'b1);
    cfgAccess(1'b0, 1'b1, 1'b0, 5'd4, 32'd0, rd, v);
    check("R9", rd, 32'd0);
    check("R9", {31'b0, v}, 32'd1);

    // R10: branch checks
    branch("R10", 32'h0000_2010, GATE, 1'b0);
    branch("R10", 32'h0000_2010, 16'h4770, 1'b1);
    branch("R10", 32'h0000_1000, 16'h4770, 1'b0);
    branch("R10", 32'h0000_0500, GATE, 1'b1);

    // R7: global disable keeps windows
    psWrite(5'd0, 32'h0);
    look("R7", 32'h0000_1000, 2'd2, 1'b0);
    psWrite(5'd0, 32'h1);
    look("R7", 32'h0000_1000, 2'd0, 1'b1);

    // Random: window programming and lookups against the model
    for (int it = 0; it < 150; it++) begin
      logic [4:0] ad;
      logic [31:0] wd;
      ad = 5'(1 + ($urandom % 16));
      wd = {16'b0, 16'($urandom)};
      if (!ad[0]) wd[1:0] = 2'($urandom);
      if (($urandom % 8) == 0) psWrite(5'd0, 32'($urandom % 2));
      psWrite(ad, wd);
      for (int k = 0; k < 6; k++) begin
        a = {3'b0, 1'($urandom % 2 == 0 && k == 0), 12'b0, 16'($urandom)};
        look("R2", a, expAttr(a), expHit(a));
        brOp = ($urandom % 2) ? GATE : 16'h0000;
        branch("R10", a, brOp, expFault(expAttr(a), brOp));
      end
    end

    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule